// File: doc/BRIEF.md
# Partial Load/Store Unit for a 16-Byte Register

This block moves a short run of bytes between a 16-byte data register and a memory that can only be reached one aligned 16-byte word at a time. A request gives a byte address, which may have any alignment, and a length operand. Only the low four bits of the length operand count, so one request moves 0 to 15 bytes. A load gathers those bytes into the low end of a 16-byte result and clears every byte above them. A store writes the low bytes of a 16-byte source register to memory starting at the given address and leaves every other memory byte as it was.

A span may sit inside one aligned word or straddle the boundary into the next one. The unit issues one or two aligned word accesses, each with a byte strobe. It splits store data across the two words and joins the two fetched words for a load. A zero-length request finishes at once with no memory traffic and no fault. A test input marks an address as invalid. A nonzero-length request to such an address raises a fault request instead of touching memory.

Top module: `span_mover`

## Requirements
- R1: The byte count is `req_len[3:0]`; the upper bits of `req_len` have no effect on strobes, data or access count.
- R2: A load returns in `rd_data` byte i (bits 8i+7..8i) the memory byte at `req_addr + i` for i below the count, and zero for every byte at or above the count.
- R3: A store writes source byte i (bits 8i+7..8i of `req_wdata`) to memory byte `req_addr + i` for i below the count; no other memory byte changes.
- R4: Any byte alignment is accepted. When offset `req_addr[3:0]` plus the count is at most 16, exactly one access is made, to word `req_addr` with its low four bits cleared.
- R5: When offset plus count exceeds 16, exactly two accesses are made: first the word holding `req_addr`, then the next word at 16 bytes higher.
- R6: Every memory access has its low four address bits zero and a nonzero byte strobe; `mem_be` bit k enables byte k of the word, and the strobes of all accesses together enable exactly the count.
- R7: A count of zero makes no memory access and raises no fault; `done` pulses in the cycle after acceptance, and a zero-length load returns all-zero data.
- R8: A nonzero count with `req_addr_bad` high makes no memory access, pulses `fault_req` in the cycle after acceptance, and gives no `done`.
- R9: `req_ready` is high only when idle. `done` is a one-cycle pulse in the cycle after the last access is acknowledged, with `done_store` telling a store from a load.
- R10: A memory request that is not acknowledged keeps its address and strobe unchanged until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when `req_ready` is high |
| req_ready | output | 1 | Unit idle and able to accept |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW (16) | Byte address, any alignment |
| req_len | input | LOPW (8) | Length operand; low 4 bits give the count |
| req_wdata | input | DW (128) | Store source register |
| req_addr_bad | input | 1 | Test flag marking the address invalid |
| mem_req | output | 1 | Memory word access pending |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (16) | Aligned word byte address |
| mem_be | output | NB (16) | Byte strobes of the access |
| mem_wdata | output | DW (128) | Write data, aligned to the word |
| mem_ack | input | 1 | Access accepted; read data valid in the same cycle |
| mem_rdata | input | DW (128) | Read word |
| done | output | 1 | One-cycle completion pulse |
| done_store | output | 1 | Completed request was a store |
| rd_data | output | DW (128) | Load result, valid with `done` when `done_store` is low |
| fault_req | output | 1 | One-cycle access-fault request pulse |

## Verification
Random loads and stores draw every offset and count, which separates spans that fit one word from spans that cross into the next. They also set random upper bits in the length operand to show those bits have no effect. Directed cases pin the exact edges. An end at byte 16 must give one access and an end at byte 17 must give two. A count of 15 at offset 15 checks the widest split, and a span at the top of the tested address range checks the wrap of the second word. Zero length and a flagged address are each tried with both load and store, and the number and placement of accesses are compared with the byte-level model each time. Memory acknowledgements come after random delays, so the held-request rule and the join of the two words are tested under stalls.

// File: rtl/pls_pkg.sv
`timescale 1ns/1ps
package pls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } pls_state_e;
endpackage

// File: rtl/pls_strobe.sv
`timescale 1ns/1ps
// Byte strobes for the low and high aligned word touched by a span.
module pls_strobe #(
  parameter int NB = 16,
  localparam int LW = $clog2(NB)
) (
  input  logic [LW-1:0] off,
  input  logic [LW-1:0] len,
  output logic [NB-1:0] be_lo,
  output logic [NB-1:0] be_hi,
  output logic          crosses
);
  logic [LW:0]     span_end;
  logic [2*NB-1:0] in_span;

  assign span_end = {1'b0, off} + {1'b0, len};
  assign crosses  = span_end > (LW+1)'(NB);

  for (genvar j = 0; j < 2*NB; j++) begin : g_pos
    localparam logic [LW+1:0] JV = (LW+2)'(j);
    assign in_span[j] = (JV >= {2'b00, off}) && (JV < {1'b0, span_end});
  end

  assign be_lo = in_span[NB-1:0];
  assign be_hi = in_span[2*NB-1:NB];

  // R6: strobes of both words enable exactly the count
  always_comb begin
    p_be_count_r6: assert ($countones(in_span) == int'(len))
      else $error("strobe count mismatch");
  end
endmodule

// File: rtl/pls_split.sv
`timescale 1ns/1ps
// Place store data at its byte offset across two aligned words.
module pls_split #(
  parameter int NB = 16,
  localparam int LW = $clog2(NB),
  localparam int DW = NB*8
) (
  input  logic [DW-1:0] src,
  input  logic [LW-1:0] off,
  output logic [DW-1:0] wd_lo,
  output logic [DW-1:0] wd_hi
);
  logic [2*DW-1:0] win;
  assign win   = {{DW{1'b0}}, src} << {off, 3'b000};
  assign wd_lo = win[DW-1:0];
  assign wd_hi = win[2*DW-1:DW];
endmodule

// File: rtl/pls_merge.sv
`timescale 1ns/1ps
// Join two fetched words, shift to the offset, clear bytes past the count.
module pls_merge #(
  parameter int NB = 16,
  localparam int LW = $clog2(NB),
  localparam int DW = NB*8
) (
  input  logic [DW-1:0] w_lo,
  input  logic [DW-1:0] w_hi,
  input  logic [LW-1:0] off,
  input  logic [LW-1:0] len,
  output logic [DW-1:0] res
);
  logic [2*DW-1:0] win;
  assign win = {w_hi, w_lo} >> {off, 3'b000};

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam logic [LW:0] IV = (LW+1)'(i);
    assign res[i*8 +: 8] = (IV < {1'b0, len}) ? win[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/span_mover.sv
`timescale 1ns/1ps
module span_mover
  import pls_pkg::*;
#(
  parameter int NB   = 16,
  parameter int AW   = 16,
  parameter int LOPW = 8,
  localparam int LW  = $clog2(NB),
  localparam int DW  = NB*8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_store,
  input  logic [AW-1:0]   req_addr,
  input  logic [LOPW-1:0] req_len,
  input  logic [DW-1:0]   req_wdata,
  input  logic            req_addr_bad,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [NB-1:0]   mem_be,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            done,
  output logic            done_store,
  output logic [DW-1:0]   rd_data,
  output logic            fault_req
);
  pls_state_e      state;
  logic [LW-1:0]   in_off, in_len;
  logic [LW-1:0]   off_q, len_q;
  logic            two_q;
  logic [NB-1:0]   be_lo, be_hi, be_hi_q;
  logic [DW-1:0]   wd_lo, wd_hi, wd_hi_q;
  logic [DW-1:0]   w_lo_q, mg_lo, merged;
  logic            crosses, accept, last_ack;

  assign in_off    = req_addr[LW-1:0];
  assign in_len    = req_len[LW-1:0];
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign last_ack  = mem_req && mem_ack &&
                     ((state == ST_HI) || (state == ST_LO && !two_q));

  pls_strobe #(.NB(NB)) u_strobe (
    .off(in_off), .len(in_len), .be_lo(be_lo), .be_hi(be_hi), .crosses(crosses)
  );

  pls_split #(.NB(NB)) u_split (
    .src(req_wdata), .off(in_off), .wd_lo(wd_lo), .wd_hi(wd_hi)
  );

  assign mg_lo = (state == ST_LO) ? mem_rdata : w_lo_q;

  pls_merge #(.NB(NB)) u_merge (
    .w_lo(mg_lo), .w_hi(mem_rdata), .off(off_q), .len(len_q), .res(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      done       <= 1'b0;
      done_store <= 1'b0;
      rd_data    <= '0;
      fault_req  <= 1'b0;
      off_q      <= '0;
      len_q      <= '0;
      two_q      <= 1'b0;
      be_hi_q    <= '0;
      wd_hi_q    <= '0;
      w_lo_q     <= '0;
    end else begin
      done      <= 1'b0;
      fault_req <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          off_q <= in_off;
          len_q <= in_len;
          if (in_len == '0) begin
            done       <= 1'b1;
            done_store <= req_store;
            if (!req_store) rd_data <= '0;
          end else if (req_addr_bad) begin
            fault_req <= 1'b1;
          end else begin
            state     <= ST_LO;
            mem_req   <= 1'b1;
            mem_we    <= req_store;
            mem_addr  <= {req_addr[AW-1:LW], {LW{1'b0}}};
            mem_be    <= be_lo;
            mem_wdata <= wd_lo;
            be_hi_q   <= be_hi;
            wd_hi_q   <= wd_hi;
            two_q     <= crosses;
          end
        end
        ST_LO: if (mem_ack) begin
          w_lo_q <= mem_rdata;
          if (two_q) begin
            state     <= ST_HI;
            mem_addr  <= mem_addr + AW'(NB);
            mem_be    <= be_hi_q;
            mem_wdata <= wd_hi_q;
          end
        end
        ST_HI: ;
        default: state <= ST_IDLE;
      endcase
      if (last_ack) begin
        state      <= ST_IDLE;
        mem_req    <= 1'b0;
        done       <= 1'b1;
        done_store <= mem_we;
        if (!mem_we) rd_data <= merged;
      end
    end
  end

  // Byte keep mask from the latched count, used only by the checks below.
  logic [DW-1:0] keep;
  for (genvar i = 0; i < NB; i++) begin : g_keep
    localparam logic [LW:0] IV = (LW+1)'(i);
    assign keep[i*8 +: 8] = (IV < {1'b0, len_q}) ? 8'hFF : 8'h00;
  end

  p_zero_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && in_len == '0) |=> (done && !mem_req && !fault_req));

  p_fault_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && in_len != '0 && req_addr_bad) |=> (fault_req && !mem_req && !done));

  p_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[LW-1:0] == '0 && mem_be != '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)));

  p_next_word_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LO && mem_ack && two_q) |=> (mem_addr == $past(mem_addr) + AW'(NB)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_zero_fill_r2: assert property (@(posedge clk) disable iff (rst)
    (done && !done_store) |-> ((rd_data & ~keep) == '0));
endmodule

// File: tb/tb_span_mover.sv
`timescale 1ns/1ps
module tb_span_mover;
  localparam int NB = 16;
  localparam int AW = 16;
  localparam int LOPW = 8;
  localparam int DW = NB*8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_store = 1'b0, req_addr_bad = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LOPW-1:0] req_len = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, mem_req, mem_we, done, done_store, fault_req;
  logic [AW-1:0] mem_addr;
  logic [NB-1:0] mem_be;
  logic [DW-1:0] mem_wdata, rd_data;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  span_mover #(.NB(NB), .AW(AW), .LOPW(LOPW)) dut (.*);

  logic [7:0] mem_b [0:255];
  logic [7:0] ref_b [0:255];
  int n_acc = 0;
  logic [7:0] first_addr = '0;
  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: random acknowledge delay, byte array storage.
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && !rst) begin
        if (dly == 0) begin
          logic [7:0] base;
          base = mem_addr[7:0];
          for (int k = 0; k < NB; k++) mem_rdata[k*8 +: 8] = mem_b[8'(base + 8'(k))];
          if (mem_we)
            for (int k = 0; k < NB; k++)
              if (mem_be[k]) mem_b[8'(base + 8'(k))] = mem_wdata[k*8 +: 8];
          if (n_acc == 0) first_addr = base;
          n_acc++;
          mem_ack = 1'b1;
          dly = $urandom % 3;
        end else dly--;
      end
    end
  end

  function automatic logic [DW-1:0] exp_load(input logic [7:0] a, input int n);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < n; i++) r[i*8 +: 8] = ref_b[8'(a + 8'(i))];
    return r;
  endfunction

  function automatic int exp_count(input logic [7:0] a, input int n, input bit bad);
    if (n == 0 || bad) return 0;
    return ((int'(a[3:0]) + n) > NB) ? 2 : 1;
  endfunction

  task automatic run_op(input bit st, input logic [7:0] a, input logic [LOPW-1:0] lop,
                        input logic [DW-1:0] wd, input bit bad, input string tag);
    int n, ec, cnt;
    logic [DW-1:0] el;
    bit mem_ok;
    n  = int'(lop[3:0]);
    ec = exp_count(a, n, bad);
    el = exp_load(a, n);
    if (st && ec > 0)
      for (int i = 0; i < n; i++) ref_b[8'(a + 8'(i))] = wd[i*8 +: 8];
    @(negedge clk);
    check(req_ready == 1'b1, {tag, " R9 ready idle"}, DW'(req_ready), DW'(1));
    n_acc = 0;
    req_valid = 1'b1; req_store = st; req_addr = {8'($urandom % 2) , a};
    req_addr = {8'h00, a};
    req_len = lop; req_wdata = wd; req_addr_bad = bad;
    @(negedge clk);
    req_valid = 1'b0; req_addr_bad = 1'b0;
    if (ec > 0) check(req_ready == 1'b0, {tag, " R9 busy"}, DW'(req_ready), DW'(0));
    cnt = 0;
    while (!(done || fault_req) && cnt < 60) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt < 60, {tag, " watchdog"}, DW'(cnt), DW'(60));
    if (bad && n != 0) begin
      check(fault_req && !done, {tag, " R8 fault"}, DW'({fault_req, done}), DW'(2'b10));
    end else begin
      check(done && !fault_req && done_store == st, {tag, " R7 R9 done"},
            DW'({done, fault_req, done_store}), DW'({1'b1, 1'b0, st}));
      if (!st) check(rd_data == el, {tag, " R1 R2 load data"}, rd_data, el);
    end
    check(n_acc == ec, {tag, " R4 R5 access count"}, DW'(n_acc), DW'(ec));
    if (ec > 0)
      check(first_addr == {a[7:4], 4'h0}, {tag, " R5 first word"},
            DW'(first_addr), DW'({a[7:4], 4'h0}));
    mem_ok = 1'b1;
    for (int i = 0; i < 256; i++) if (mem_b[i] !== ref_b[i]) mem_ok = 1'b0;
    check(mem_ok, {tag, " R3 memory image"}, DW'(mem_ok), DW'(1));
    @(negedge clk);
    check(!done && !fault_req, {tag, " R9 one-cycle pulse"},
          DW'({done, fault_req}), DW'(0));
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem_b[i] = 8'($urandom);
      ref_b[i] = mem_b[i];
    end
    repeat (3) @(negedge clk);
    check(req_ready && !mem_req && !done && !fault_req, "reset state R9",
          DW'({req_ready, mem_req, done, fault_req}), DW'(4'b1000));
    rst = 1'b0;
    @(negedge clk);
    // Directed corners
    run_op(0, 8'h23, 8'h00, '0, 0, "R7 zero load");
    run_op(1, 8'h37, 8'hF0, rnd_word(), 0, "R7 zero store upper bits");
    run_op(1, 8'h37, 8'h00, rnd_word(), 1, "R7 zero store flagged");
    run_op(0, 8'h45, 8'h06, '0, 1, "R8 flagged load");
    run_op(1, 8'h45, 8'h06, rnd_word(), 1, "R8 flagged store");
    run_op(0, 8'h40, 8'h0F, '0, 0, "R4 aligned load");
    run_op(0, 8'h51, 8'h0F, '0, 0, "R4 end at 16");
    run_op(0, 8'h62, 8'h0F, '0, 0, "R5 end at 17");
    run_op(0, 8'h7F, 8'h0F, '0, 0, "R5 widest split load");
    run_op(1, 8'h8F, 8'h0F, rnd_word(), 0, "R5 widest split store");
    run_op(1, 8'hF9, 8'h0C, rnd_word(), 0, "R5 wrap store");
    run_op(0, 8'hF9, 8'h0C, '0, 0, "R5 wrap load");
    run_op(0, 8'h33, 8'hA5, '0, 0, "R1 upper bits load");
    run_op(1, 8'h3B, 8'h5A, rnd_word(), 0, "R1 upper bits store");
    // Random mix
    for (int t = 0; t < 300; t++)
      run_op(1'($urandom), 8'($urandom), 8'($urandom), rnd_word(),
             ($urandom % 10) == 0, "random R2 R3 R6 R10");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired R9 actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule